// File: doc/BRIEF.md
# Selectable Time Base with Watchdog

This block turns a 32768 Hz reference into the periodic pulses that interrupt and wake-up logic use. It has four tick outputs: 2048 Hz, 128 Hz, a fast tick that can be set to 4, 8, 16 or 32 Hz, and a slow tick that can be set to 2 or 1 Hz. The block runs on the system clock. `ref_pulse` is a clock enable that is high for one system cycle per period of the 32768 Hz reference. The divider and the watchdog advance only on those cycles, so stopping the oscillator also freezes both of them.

The block also has a watchdog timer. While it is enabled, it raises `sys_rst` for one cycle when one second of reference periods has passed without a clear. Software writes to the block over a simple write strobe bus. A write to address 0x0A sets the tick selection. A write of the key value 0x0F to address 0x0F clears the watchdog.

The watchdog is a three-state machine:
- WD_OFF: disabled. `wd_en` high moves it to WD_RUN.
- WD_RUN: counting. `wd_en` low moves it to WD_OFF. When the count reaches its last value on a reference cycle with no clear, it moves to WD_BITE.
- WD_BITE: asserts `sys_rst` for one cycle. It then returns to WD_RUN if `wd_en` is high, or to WD_OFF if it is low.

Top module: `timebase_wdog`

## Requirements
- R1: After reset, all tick outputs and `sys_rst` are low. The fast tick selection defaults to 4 Hz and the slow tick selection to 2 Hz.
- R2: The 2048 Hz tick pulses once every 16 reference periods. Counting the reference cycles since reset as n, it pulses in the cycle after n reaches a value with n mod 16 = 8.
- R3: The 128 Hz tick pulses once every 256 reference periods, in the cycle after n mod 256 = 128.
- R4: Bits [1:0] of a write to address 0x0A select the fast tick period:
  - 00: 8192 reference periods (4 Hz)
  - 01: 4096 (8 Hz)
  - 10: 2048 (16 Hz)
  - 11: 1024 (32 Hz)

  For a period P, the tick pulses in the cycle after n mod P = P/2.
- R5: Bit 7 of a write to address 0x0A selects the slow tick: 0 gives 2 Hz (a period of 16384) and 1 gives 1 Hz (32768). The phase rule is the same as in R4.
- R6: Every tick is exactly one system cycle wide. Changing a selection never produces a pulse outside the phase rule of the newly selected rate.
- R7: On a cycle with `ref_pulse` low, neither the divider nor the watchdog count advances, and no tick fires.
- R8: While `wd_en` is high, `sys_rst` pulses for one cycle once 32768 reference periods have passed since enabling, since the last clear or since the previous pulse.
- R9: Writing data 0x0F to address 0x0F restarts the watchdog count from zero.
- R10: A write to address 0x0F with data other than 0x0F, or a write of 0x0F to any other address, does not affect the watchdog. Writes to addresses other than 0x0A do not change the tick selection.
- R11: While `wd_en` is low, the watchdog count is held at zero and `sys_rst` stays low. Enabling it again starts a full count of 32768.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_pulse | input | 1 | One-cycle enable per 32768 Hz reference period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data |
| wd_en | input | 1 | Watchdog enable |
| tick_2k | output | 1 | 2048 Hz pulse |
| tick_128 | output | 1 | 128 Hz pulse |
| tick_fast | output | 1 | Selectable 4/8/16/32 Hz pulse |
| tick_slow | output | 1 | Selectable 2/1 Hz pulse |
| sys_rst | output | 1 | One-cycle watchdog reset request |

## Verification
- **Divider errors:** a wrong divider count or wrong edge history makes a tick appear off its phase. For the 2048 Hz tick this shows within 16 reference cycles; for the selected slow tick it can take up to one full slow period.
- **Selection register errors:** a wrong selection register shows up as the wrong period at the next pulse of that tick.
- **Watchdog errors:** a wrong count, or a clear that is missed or taken when it should not be, is only visible when `sys_rst` fires early or late. That is about one second of reference cycles later. The bench therefore compares the exact cycle of the pulse against the cycle of the last enable or clear, with deliberate reference stalls in between.

// File: rtl/tbw_pkg.sv
package tbw_pkg;

    localparam logic [7:0] ADDR_TSET  = 8'h0A;
    localparam logic [7:0] ADDR_WDCLR = 8'h0F;
    localparam logic [7:0] WD_KEY     = 8'h0F;

    // Number of tapped divider bits:
    // 2k, 128, four fast rates, two slow rates.
    localparam int TAP_N = 8;

    typedef enum logic [1:0] {
        WD_OFF  = 2'd0,
        WD_RUN  = 2'd1,
        WD_BITE = 2'd2
    } wd_state_t;

    typedef struct packed {
        logic       slow_1hz;
        logic [1:0] fast_sel;
    } tset_t;

endpackage

// File: rtl/tbw_divider.sv
module tbw_divider
    import tbw_pkg::*;
#(
    parameter int DIV_W = 15,
    parameter int B_2K  = 3,
    parameter int B_128 = 7,
    parameter int B_F32 = 9,
    parameter int B_S2  = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_pulse,
    output logic [TAP_N-1:0] edges
);

    logic [DIV_W-1:0] cnt;
    logic [TAP_N-1:0] taps;
    logic [TAP_N-1:0] taps_q;

    // Free-running ripple count, advanced only by the reference enable.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            taps_q <= '0;
        end else begin
            if (ref_pulse) begin
                cnt <= cnt + 1'b1;
            end
            taps_q <= taps;
        end
    end

    assign taps[0] = cnt[B_2K];
    assign taps[1] = cnt[B_128];

    // Fast taps: tap 2 is 32 Hz ... tap 5 is 4 Hz.
    for (genvar f = 0; f < 4; f++) begin : g_fast
        assign taps[2+f] = cnt[B_F32+f];
    end

    // Slow taps: tap 6 is 2 Hz, tap 7 is 1 Hz.
    for (genvar s = 0; s < 2; s++) begin : g_slow
        assign taps[6+s] = cnt[B_S2+s];
    end

    for (genvar t = 0; t < TAP_N; t++) begin : g_edge
        assign edges[t] = taps[t] & ~taps_q[t];

        a_r6_tap_single : assert property (
            @(posedge clk) disable iff (!rst_n)
            edges[t] |=> !edges[t]
        );
    end

    a_r7_no_ref_no_edge : assert property (
        @(posedge clk) disable iff (!rst_n)
        !ref_pulse |=> (edges == '0)
    );

endmodule

// File: rtl/tbw_tick_sel.sv
module tbw_tick_sel
    import tbw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_we,
    input  tset_t            set_val,
    input  logic [TAP_N-1:0] edges,
    output logic             tick_2k,
    output logic             tick_128,
    output logic             tick_fast,
    output logic             tick_slow
);

    tset_t tset;

    // Selection register; reset gives 4 Hz fast and 2 Hz slow (R1).
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tset <= '0;
        end else if (set_we) begin
            tset <= set_val;
        end
    end

    always_comb begin
        tick_2k  = edges[0];
        tick_128 = edges[1];

        unique case (tset.fast_sel)
            2'b00:   tick_fast = edges[5];
            2'b01:   tick_fast = edges[4];
            2'b10:   tick_fast = edges[3];
            2'b11:   tick_fast = edges[2];
            default: tick_fast = 1'b0;
        endcase

        tick_slow = tset.slow_1hz ? edges[7] : edges[6];
    end

    a_r6_fast_single : assert property (
        @(posedge clk) disable iff (!rst_n)
        tick_fast |=> !tick_fast
    );

    a_r6_slow_single : assert property (
        @(posedge clk) disable iff (!rst_n)
        tick_slow |=> !tick_slow
    );

endmodule

// File: rtl/tbw_watchdog.sv
module tbw_watchdog
    import tbw_pkg::*;
#(
    parameter int WD_LIMIT = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_pulse,
    input  logic wd_en,
    input  logic kick,
    output logic sys_rst
);

    localparam int            CW   = $clog2(WD_LIMIT);
    localparam logic [CW-1:0] LAST = CW'(WD_LIMIT - 1);

    wd_state_t     state;
    wd_state_t     nxt;
    logic [CW-1:0] cnt;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= WD_OFF;
        end else begin
            state <= nxt;
        end
    end

    // Transitions.
    always_comb begin
        nxt = state;
        unique case (state)
            WD_OFF: begin
                if (wd_en) nxt = WD_RUN;
            end
            WD_RUN: begin
                if (!wd_en) begin
                    nxt = WD_OFF;
                end else if (ref_pulse && !kick && cnt == LAST) begin
                    nxt = WD_BITE;
                end
            end
            WD_BITE: begin
                nxt = wd_en ? WD_RUN : WD_OFF;
            end
            default: nxt = WD_OFF;
        endcase
    end

    // Count: held at zero outside WD_RUN, restarted by the key.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (state != WD_RUN || !wd_en || kick) begin
            cnt <= '0;
        end else if (ref_pulse) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    // Outputs.
    always_comb begin
        sys_rst = (state == WD_BITE);
    end

    a_r8_bite_single : assert property (
        @(posedge clk) disable iff (!rst_n)
        sys_rst |=> !sys_rst
    );

    a_r9_kick_defers : assert property (
        @(posedge clk) disable iff (!rst_n)
        (state == WD_RUN && kick) |=> !sys_rst
    );

    a_r11_off_quiet : assert property (
        @(posedge clk) disable iff (!rst_n)
        !wd_en |=> !sys_rst
    );

    a_r7_no_ref_no_bite : assert property (
        @(posedge clk) disable iff (!rst_n)
        (state == WD_RUN && !ref_pulse) |=> !sys_rst
    );

endmodule

// File: rtl/timebase_wdog.sv
module timebase_wdog
    import tbw_pkg::*;
#(
    parameter int REF_HZ = 32768
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_pulse,
    input  logic       wr_en,
    input  logic [7:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       wd_en,
    output logic       tick_2k,
    output logic       tick_128,
    output logic       tick_fast,
    output logic       tick_slow,
    output logic       sys_rst
);

    localparam int DIV_W = $clog2(REF_HZ);
    localparam int B_2K  = $clog2(REF_HZ / 2048) - 1;
    localparam int B_128 = $clog2(REF_HZ / 128) - 1;
    localparam int B_F32 = $clog2(REF_HZ / 32) - 1;
    localparam int B_S2  = $clog2(REF_HZ / 2) - 1;

    logic [TAP_N-1:0] edges;
    logic             tset_we;
    tset_t            tset_val;
    logic             kick;

    assign tset_we  = wr_en && (wr_addr == ADDR_TSET);
    assign tset_val = {wr_data[7], wr_data[1:0]};
    assign kick     = wr_en && (wr_addr == ADDR_WDCLR) && (wr_data == WD_KEY);

    tbw_divider #(
        .DIV_W (DIV_W),
        .B_2K  (B_2K),
        .B_128 (B_128),
        .B_F32 (B_F32),
        .B_S2  (B_S2)
    ) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_pulse (ref_pulse),
        .edges     (edges)
    );

    tbw_tick_sel u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_we    (tset_we),
        .set_val   (tset_val),
        .edges     (edges),
        .tick_2k   (tick_2k),
        .tick_128  (tick_128),
        .tick_fast (tick_fast),
        .tick_slow (tick_slow)
    );

    tbw_watchdog #(
        .WD_LIMIT (REF_HZ)
    ) u_wdog (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_pulse (ref_pulse),
        .wd_en     (wd_en),
        .kick      (kick),
        .sys_rst   (sys_rst)
    );

endmodule

// File: tb/timebase_wdog_test.sv
module timebase_wdog_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_pulse = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic       wd_en = 1'b0;
    logic       tick_2k, tick_128, tick_fast, tick_slow, sys_rst;

    int checks = 0;
    int errors = 0;
    int rc;
    bit adv;
    bit finished = 0;

    always #5 clk = ~clk;

    timebase_wdog uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_pulse (ref_pulse),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wd_en     (wd_en),
        .tick_2k   (tick_2k),
        .tick_128  (tick_128),
        .tick_fast (tick_fast),
        .tick_slow (tick_slow),
        .sys_rst   (sys_rst)
    );

    // Reference cycles seen since reset, and whether the last edge advanced.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rc  <= 0;
            adv <= 1'b0;
        end else begin
            rc  <= rc + (ref_pulse ? 1 : 0);
            adv <= ref_pulse;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int got, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    function automatic logic pick(input int which);
        case (which)
            0:       return tick_2k;
            1:       return tick_128;
            2:       return tick_fast;
            default: return tick_slow;
        endcase
    endfunction

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic set_en(input logic v);
        @(negedge clk);
        wd_en = v;
        @(negedge clk);
    endtask

    // Follows one tick until its next pulse and checks every cycle against the phase rule.
    task automatic await_tick(input int which, input int period,
                              input string req, input string what);
        int  bad = 0;
        bit  seen = 0;
        for (int i = 0; i < 2 * period + 4 && !seen; i++) begin
            logic e;
            @(negedge clk);
            e = adv && (rc % period == period / 2);
            if (pick(which) !== e) bad++;
            if (e) seen = 1;
        end
        check(seen && bad == 0, req, what, bad, 0);
        @(negedge clk);
        check(pick(which) == 1'b0, "R6", {what, " one cycle wide"}, int'(pick(which)), 0);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        check({tick_2k, tick_128, tick_fast, tick_slow, sys_rst} == 5'b0, "R1",
              "outputs during reset", int'({tick_2k, tick_128, tick_fast, tick_slow, sys_rst}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({tick_2k, tick_128, tick_fast, tick_slow, sys_rst} == 5'b0, "R1",
              "outputs after reset", int'({tick_2k, tick_128, tick_fast, tick_slow, sys_rst}), 0);
    endtask

    task automatic t_stall;
        int bad = 0;
        @(negedge clk);
        ref_pulse = 1'b0;
        repeat (40) begin
            @(negedge clk);
            if ({tick_2k, tick_128, tick_fast, tick_slow} != 4'b0) bad++;
        end
        ref_pulse = 1'b1;
        check(bad == 0, "R7", "ticks while reference stalled", bad, 0);
        await_tick(0, 16, "R7", "2k phase after stall");
    endtask

    task automatic t_fast_rates;
        await_tick(2, 8192, "R1", "default fast 4 Hz");
        wr(8'h0A, 8'h01);
        await_tick(2, 4096, "R4", "fast 8 Hz");
        wr(8'h0A, 8'h02);
        await_tick(2, 2048, "R4", "fast 16 Hz");
        wr(8'h0A, 8'h03);
        await_tick(2, 1024, "R4", "fast 32 Hz");
        wr(8'h0B, 8'h00);
        await_tick(2, 1024, "R10", "fast kept after foreign write");
    endtask

    task automatic t_slow_rates;
        await_tick(3, 16384, "R5", "default slow 2 Hz");
        wr(8'h0A, 8'h83);
        await_tick(3, 32768, "R5", "slow 1 Hz");
        await_tick(2, 1024, "R4", "fast 32 Hz kept by 0x83");
    endtask

    task automatic wd_quiet(input int n, input string req, input string what);
        int bad = 0;
        repeat (n) begin
            @(negedge clk);
            if (sys_rst) bad++;
        end
        check(bad == 0, req, what, bad, 0);
    endtask

    // Expects sys_rst high exactly fire_at edges after the last enable or clear.
    task automatic wd_watch(input int fire_at, input string req, input string what,
                            input bit inject, input bit stall);
        int early = 0;
        bit hit = 0;
        for (int i = 1; i <= fire_at + 1; i++) begin
            @(negedge clk);
            if (i == fire_at) hit = sys_rst;
            else if (sys_rst) early++;
            if (inject) begin
                if (i == 100) begin wr_en = 1'b1; wr_addr = 8'h0F; wr_data = 8'h0E; end
                if (i == 101) begin wr_addr = 8'h0B; wr_data = 8'h0F; end
                if (i == 102) wr_en = 1'b0;
            end
            if (stall) begin
                if (i == 200) ref_pulse = 1'b0;
                if (i == 250) ref_pulse = 1'b1;
            end
        end
        check(hit, req, {what, " pulse at expected cycle"}, int'(hit), 1);
        check(early == 0, "R8", {what, " no pulse elsewhere"}, early, 0);
    endtask

    task automatic t_wd_disable_and_ignore;
        set_en(1'b1);
        wd_quiet(2000, "R8", "no early bite");
        set_en(1'b0);
        wd_quiet(50, "R11", "disabled stays quiet");
        set_en(1'b1);
        wd_watch(32768, "R10,R11", "bad writes ignored, fresh count", 1'b1, 1'b0);
    endtask

    task automatic t_wd_clear_and_stall;
        wd_quiet(16000, "R8", "quiet before clear");
        wr(8'h0F, 8'h0F);
        wd_watch(32768 + 50, "R9,R7", "clear restarts, stall delays", 1'b0, 1'b1);
    endtask

    initial begin
        t_reset();
        await_tick(0, 16, "R2", "2k tick");
        t_stall();
        await_tick(1, 256, "R3", "128 Hz tick");
        t_fast_rates();
        t_slow_rates();
        t_wd_disable_and_ignore();
        t_wd_clear_and_stall();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL bench timeout (all requirements): got 190000 cycles expected fewer");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule